// File: doc/BRIEF.md
# Bit-Test and Decrement Branch Resolver

This unit resolves the conditional branches of a small 8-bit processor core over several clock cycles. Once a request is accepted it reads one operand byte through a data port and tests a selected bit of it, or decrements it. When the form calls for it, the unit writes the modified byte back through the same location. It then reports the next program counter together with a one-cycle completion pulse. Four branch kinds are supported: branch when a bit is one, branch when a bit is zero, branch when a bit is one and then clear that bit, and decrement followed by branch when the result is non-zero.

The operand can be one of several sources: a short-direct memory byte, a special register, the accumulator, the status byte, a byte addressed through the indirect pointer pair, or one of the two counter registers. The source sets both the instruction length and the cycle budget. A read handshake (`opnd_rd`/`opnd_rd_ok`) and a write handshake (`opnd_wr`/`opnd_wr_ok`) let slow external memory add wait cycles. Each cycle in which a strobe is high while its ready input is low lengthens the instruction by one cycle.

The surrounding core holds the operand address, decodes the instruction and owns the register file. A write-back to the status byte replaces the stored flag bits with the written byte. The unit itself has no flag logic.

Top module: `bitbr_unit`

## Requirements
- R1: Kind code 0 (bit-set test) branches when bit `req_bit` of the operand is 1. Kind code 1 (bit-clear test) branches when that bit is 0. Neither kind ever raises `opnd_wr`.
- R2: Kind code 2 (test-and-clear) branches when the selected bit is 1. Only on that taken path does it write the operand back with the selected bit forced to 0 and every other bit unchanged. When the branch is not taken, no write occurs.
- R3: Kind code 3 (decrement) always writes back the operand minus one, modulo 256, so 0x00 becomes 0xFF. It branches when that written value is non-zero.
- R4: While `done` is high, `next_pc` equals `req_pc + L + sign-extended req_disp` modulo 2^16 if the branch is taken, and `req_pc + L` if it is not. L is the instruction length.
- R5: Source codes are: 0 short-direct, 1 special register, 2 accumulator, 3 status byte, 4 indirect, 5 counter B, 6 counter C. The pair (length, cycles) for each kind and source is:
  - Kind 0: src0 (3,8), src1 (4,11), src2 (3,8), src3 (3,9), src4 (3,10).
  - Kind 1: src0 (4,10), src1 (4,11), src2 (3,8), src3 (4,11), src4 (3,10).
  - Kind 2: src0 (4,10), src1 (4,12), src2 (3,8), src3 (4,12), src4 (3,10).
  - Kind 3: src5 (2,6), src6 (2,6), src0 (3,8).
- R6: The request cycle counts as cycle 1. With no wait cycles, `done` is high in cycle number `cycles` of the form. Each cycle in which `opnd_rd` is high and `opnd_rd_ok` is low adds one cycle.
- R7: Each cycle in which `opnd_wr` is high and `opnd_wr_ok` is low adds one cycle. `opnd_wr_data` holds steady during those cycles.
- R8: A request is accepted only while the unit is idle. A request raised while the unit is busy is ignored. A request whose kind and source pair is not listed in R5 is ignored: no read, no write and no `done` follow it.
- R9: While reset is applied, `done`, `opnd_rd` and `opnd_wr` are all low.
- R10: `done` is high for exactly one cycle per accepted request. `opnd_rd` is high in the cycle after acceptance and stays high until `opnd_rd_ok` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_kind | input | 2 | Branch kind code (0..3) |
| req_src | input | 3 | Operand source code (0..6) |
| req_bit | input | 3 | Bit index to test or clear |
| req_pc | input | 16 | Program counter of the branch |
| req_disp | input | 8 | Signed displacement |
| opnd_rd | output | 1 | Operand read strobe |
| opnd_rd_ok | input | 1 | Read ready; low inserts a wait cycle |
| opnd_rd_data | input | 8 | Operand byte, taken when read is ready |
| opnd_wr | output | 1 | Write-back strobe |
| opnd_wr_data | output | 8 | Write-back byte |
| opnd_wr_ok | input | 1 | Write ready; low inserts a wait cycle |
| next_pc | output | 16 | Resolved next program counter, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the remaining-cycle counter is loaded or decremented wrongly, `done` shows up in the wrong cycle. The bench sees this at the end of that same instruction as a cycle-count mismatch. If the latched operand byte or bit index is wrong, the result shows up as a bad `opnd_wr_data` in the write cycle, or as a wrong taken decision visible in `next_pc` while `done` is high. A busy request that is wrongly accepted, or an illegal request, produces an extra read strobe or an extra `done` that the scoreboard finds with no matching expected entry.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;
  typedef enum logic [1:0] {
    K_BIT_ONE  = 2'd0,
    K_BIT_ZERO = 2'd1,
    K_BIT_TCLR = 2'd2,
    K_DEC_NZ   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_DIRECT  = 3'd0,
    S_SPECIAL = 3'd1,
    S_ACCUM   = 3'd2,
    S_STATUS  = 3'd3,
    S_INDIR   = 3'd4,
    S_CNT_B   = 3'd5,
    S_CNT_C   = 3'd6,
    S_RSVD    = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READ  = 3'd1,
    PH_WRITE = 3'd2,
    PH_COUNT = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;
endpackage

// File: rtl/bitbr_decode.sv
module bitbr_decode
  import bitbr_pkg::*;
#(
  parameter int CYC_W = 5,
  parameter int LEN_W = 3
) (
  input  kind_e             kind,
  input  src_e              src,
  output logic              legal,
  output logic [LEN_W-1:0]  len,
  output logic [CYC_W-1:0]  cycles
);
  always_comb begin
    legal  = 1'b1;
    len    = LEN_W'(3);
    cycles = CYC_W'(8);
    case (kind)
      K_BIT_ONE: begin
        case (src)
          S_DIRECT:  begin len = LEN_W'(3); cycles = CYC_W'(8);  end
          S_SPECIAL: begin len = LEN_W'(4); cycles = CYC_W'(11); end
          S_ACCUM:   begin len = LEN_W'(3); cycles = CYC_W'(8);  end
          S_STATUS:  begin len = LEN_W'(3); cycles = CYC_W'(9);  end
          S_INDIR:   begin len = LEN_W'(3); cycles = CYC_W'(10); end
          default:   legal = 1'b0;
        endcase
      end
      K_BIT_ZERO: begin
        case (src)
          S_DIRECT:  begin len = LEN_W'(4); cycles = CYC_W'(10); end
          S_SPECIAL: begin len = LEN_W'(4); cycles = CYC_W'(11); end
          S_ACCUM:   begin len = LEN_W'(3); cycles = CYC_W'(8);  end
          S_STATUS:  begin len = LEN_W'(4); cycles = CYC_W'(11); end
          S_INDIR:   begin len = LEN_W'(3); cycles = CYC_W'(10); end
          default:   legal = 1'b0;
        endcase
      end
      K_BIT_TCLR: begin
        case (src)
          S_DIRECT:  begin len = LEN_W'(4); cycles = CYC_W'(10); end
          S_SPECIAL: begin len = LEN_W'(4); cycles = CYC_W'(12); end
          S_ACCUM:   begin len = LEN_W'(3); cycles = CYC_W'(8);  end
          S_STATUS:  begin len = LEN_W'(4); cycles = CYC_W'(12); end
          S_INDIR:   begin len = LEN_W'(3); cycles = CYC_W'(10); end
          default:   legal = 1'b0;
        endcase
      end
      default: begin
        case (src)
          S_CNT_B:  begin len = LEN_W'(2); cycles = CYC_W'(6); end
          S_CNT_C:  begin len = LEN_W'(2); cycles = CYC_W'(6); end
          S_DIRECT: begin len = LEN_W'(3); cycles = CYC_W'(8); end
          default:  legal = 1'b0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/bitbr_alu.sv
module bitbr_alu
  import bitbr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  kind_e              kind,
  input  logic [BIT_W-1:0]   bit_idx,
  input  logic [DATA_W-1:0]  opnd,
  output logic               taken,
  output logic               wb_need,
  output logic [DATA_W-1:0]  wb_data
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] dec_val;
  logic              sel_bit;

  always_comb begin
    mask    = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;
    sel_bit = |(opnd & mask);
    dec_val = opnd - {{(DATA_W-1){1'b0}}, 1'b1};
    taken   = 1'b0;
    wb_need = 1'b0;
    wb_data = opnd;
    case (kind)
      K_BIT_ONE:  taken = sel_bit;
      K_BIT_ZERO: taken = ~sel_bit;
      K_BIT_TCLR: begin
        taken   = sel_bit;
        wb_need = sel_bit;
        wb_data = opnd & ~mask;
      end
      default: begin
        taken   = |dec_val;
        wb_need = 1'b1;
        wb_data = dec_val;
      end
    endcase
  end

  // R2: a bit-form write-back differs from the operand in at most one bit
  always_comb begin
    if (kind != K_DEC_NZ) begin
      p_one_bit_r2: assert ($countones(opnd ^ wb_data) <= 1);
    end
  end
endmodule

// File: rtl/bitbr_target.sv
module bitbr_target #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [LEN_W-1:0]  len,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [PC_W-1:0]   next_pc
);
  logic [PC_W-1:0] disp_ext;
  logic [PC_W-1:0] seq_pc;

  generate
    if (PC_W > DISP_W) begin : g_sext
      assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    seq_pc  = pc + PC_W'(len);
    next_pc = taken ? (seq_pc + disp_ext) : seq_pc;
  end
endmodule

// File: rtl/bitbr_unit.sv
module bitbr_unit
  import bitbr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int DISP_W = 8,
  parameter int CYC_W  = 5,
  localparam int BIT_W = $clog2(DATA_W),
  localparam int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_src,
  input  logic [BIT_W-1:0]  req_bit,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [DISP_W-1:0] req_disp,
  output logic              opnd_rd,
  input  logic              opnd_rd_ok,
  input  logic [DATA_W-1:0] opnd_rd_data,
  output logic              opnd_wr,
  output logic [DATA_W-1:0] opnd_wr_data,
  input  logic              opnd_wr_ok,
  output logic [PC_W-1:0]   next_pc,
  output logic              done
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  phase_e             phase_q, phase_d;
  logic [CYC_W-1:0]   cnt_q, cnt_d;
  kind_e              kind_q;
  logic [BIT_W-1:0]   bit_q;
  logic [PC_W-1:0]    pc_q;
  logic [DISP_W-1:0]  disp_q;
  logic [LEN_W-1:0]   len_q;
  logic [DATA_W-1:0]  opnd_q;

  logic               dec_legal;
  logic [LEN_W-1:0]   dec_len;
  logic [CYC_W-1:0]   dec_cycles;
  logic               accept, opnd_load, tick, last;
  logic [DATA_W-1:0]  alu_in;
  logic               alu_taken, alu_wb_need;
  logic [DATA_W-1:0]  alu_wb_data;

  bitbr_decode #(.CYC_W(CYC_W), .LEN_W(LEN_W)) u_decode (
    .kind   (kind_e'(req_kind)),
    .src    (src_e'(req_src)),
    .legal  (dec_legal),
    .len    (dec_len),
    .cycles (dec_cycles)
  );

  assign alu_in = (phase_q == PH_READ) ? opnd_rd_data : opnd_q;

  bitbr_alu #(.DATA_W(DATA_W)) u_alu (
    .kind    (kind_q),
    .bit_idx (bit_q),
    .opnd    (alu_in),
    .taken   (alu_taken),
    .wb_need (alu_wb_need),
    .wb_data (alu_wb_data)
  );

  bitbr_target #(.PC_W(PC_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_target (
    .pc      (pc_q),
    .len     (len_q),
    .disp    (disp_q),
    .taken   (alu_taken),
    .next_pc (next_pc)
  );

  // next-state logic
  always_comb begin
    accept    = (phase_q == PH_IDLE) && req_valid && dec_legal;
    opnd_load = (phase_q == PH_READ) && opnd_rd_ok;
    tick      = opnd_load ||
                ((phase_q == PH_WRITE) && opnd_wr_ok) ||
                (phase_q == PH_COUNT);
    last      = (cnt_q == CYC_W'(1));
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    if (accept) begin
      cnt_d = dec_cycles - CYC_W'(2);
    end else if (tick) begin
      cnt_d = cnt_q - CYC_W'(1);
    end
    case (phase_q)
      PH_IDLE:  if (accept) phase_d = PH_READ;
      PH_READ: begin
        if (opnd_rd_ok) begin
          if (last)             phase_d = PH_DONE;
          else if (alu_wb_need) phase_d = PH_WRITE;
          else                  phase_d = PH_COUNT;
        end
      end
      PH_WRITE: if (opnd_wr_ok) phase_d = last ? PH_DONE : PH_COUNT;
      PH_COUNT: if (last) phase_d = PH_DONE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      kind_q <= K_BIT_ONE;
      bit_q  <= '0;
      pc_q   <= '0;
      disp_q <= '0;
      len_q  <= '0;
    end else if (accept) begin
      kind_q <= kind_e'(req_kind);
      bit_q  <= req_bit;
      pc_q   <= req_pc;
      disp_q <= req_disp;
      len_q  <= dec_len;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      opnd_q <= '0;
    end else if (opnd_load) begin
      opnd_q <= opnd_rd_data;
    end
  end

  assign opnd_rd      = (phase_q == PH_READ);
  assign opnd_wr      = (phase_q == PH_WRITE);
  assign opnd_wr_data = alu_wb_data;
  assign done         = (phase_q == PH_DONE);

  // R6: a read strobe without ready persists
  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_q)
    opnd_rd && !opnd_rd_ok |=> opnd_rd);

  // R7: write strobe and data persist through write wait cycles
  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_q)
    opnd_wr && !opnd_wr_ok |=> opnd_wr && $stable(opnd_wr_data));

  // R10: completion lasts one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);

  // R6: counting phase never runs with an exhausted budget
  p_cnt_live_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (phase_q == PH_COUNT) |-> (cnt_q != '0));

  // R8: a request while busy leaves the captured program counter unchanged
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (phase_q != PH_IDLE) && req_valid |=> $stable(pc_q));
endmodule

// File: tb/bitbr_unit_test.sv
module bitbr_unit_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [2:0]  req_src;
  logic [2:0]  req_bit;
  logic [15:0] req_pc;
  logic [7:0]  req_disp;
  logic        opnd_rd, opnd_rd_ok;
  logic [7:0]  opnd_rd_data;
  logic        opnd_wr, opnd_wr_ok;
  logic [7:0]  opnd_wr_data;
  logic [15:0] next_pc;
  logic        done;

  bitbr_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_src(req_src), .req_bit(req_bit), .req_pc(req_pc), .req_disp(req_disp),
    .opnd_rd(opnd_rd), .opnd_rd_ok(opnd_rd_ok), .opnd_rd_data(opnd_rd_data),
    .opnd_wr(opnd_wr), .opnd_wr_data(opnd_wr_data), .opnd_wr_ok(opnd_wr_ok),
    .next_pc(next_pc), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] pc;
    logic        wb;
    logic [7:0]  wbv;
    int          cyc;
    int          t0;
    string       tag;
    string       ctag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  int g_rw = 0, g_ww = 0, rdw = 0, wrw = 0;
  logic [7:0] g_opnd = 8'h00;
  bit wr_seen = 0;
  logic [7:0] wr_val = 8'h00;
  bit stray = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // operand location model with programmable wait cycles
  always @(negedge clk) begin
    if (opnd_rd) begin
      if (rdw < g_rw) begin opnd_rd_ok = 1'b0; rdw++; end
      else begin opnd_rd_ok = 1'b1; opnd_rd_data = g_opnd; end
    end else begin
      opnd_rd_ok = 1'b0; rdw = 0;
    end
    if (opnd_wr) begin
      if (wrw < g_ww) begin opnd_wr_ok = 1'b0; wrw++; end
      else opnd_wr_ok = 1'b1;
    end else begin
      opnd_wr_ok = 1'b0; wrw = 0;
    end
  end

  // monitor: compares each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (q.size() == 0 && (opnd_rd || opnd_wr || done)) stray = 1;
      if (opnd_wr) begin wr_seen = 1; wr_val = opnd_wr_data; end
      if (done) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 unexpected done actual=1 expected=0");
        end else begin
          item_t it;
          int meas;
          it = q.pop_front();
          meas = cyc - it.t0 + 1;
          checks++;
          if (meas != it.cyc) begin
            errors++;
            $display("FAIL %s done cycle actual=%0d expected=%0d", it.ctag, meas, it.cyc);
          end
          checks++;
          if (next_pc !== it.pc) begin
            errors++;
            $display("FAIL R4 %s next_pc actual=%h expected=%h", it.tag, next_pc, it.pc);
          end
          checks++;
          if (wr_seen != it.wb || (it.wb && wr_val !== it.wbv)) begin
            errors++;
            $display("FAIL %s write-back actual=%0d/%h expected=%0d/%h",
                     it.tag, wr_seen, wr_val, it.wb, it.wbv);
          end
        end
        wr_seen = 0;
      end
    end
  end

  function automatic int e_len(int k, int s);
    case (k)
      0: case (s) 1: return 4; default: return 3; endcase
      1, 2: case (s) 2, 4: return 3; default: return 4; endcase
      default: case (s) 0: return 3; default: return 2; endcase
    endcase
  endfunction

  function automatic int e_cyc(int k, int s);
    case (k)
      0: case (s) 0: return 8; 1: return 11; 2: return 8; 3: return 9; default: return 10; endcase
      1: case (s) 0: return 10; 1: return 11; 2: return 8; 3: return 11; default: return 10; endcase
      2: case (s) 0: return 10; 1: return 12; 2: return 8; 3: return 12; default: return 10; endcase
      default: case (s) 0: return 8; default: return 6; endcase
    endcase
  endfunction

  task automatic run(input int k, input int s, input int b, input logic [15:0] pc,
                     input logic [7:0] disp, input logic [7:0] opnd,
                     input int rw, input int ww, input bit inject,
                     input string tag, input string ctag);
    item_t it;
    bit tk;
    logic [7:0] dv;
    it.wb = 0; it.wbv = 8'h00;
    dv = opnd - 8'd1;
    case (k)
      0: tk = opnd[b];
      1: tk = !opnd[b];
      2: begin tk = opnd[b]; it.wb = tk; it.wbv = opnd & ~(8'd1 << b); end
      default: begin tk = (dv != 0); it.wb = 1; it.wbv = dv; end
    endcase
    it.pc = pc + 16'(e_len(k, s)) + (tk ? {{8{disp[7]}}, disp} : 16'h0);
    it.cyc = e_cyc(k, s) + rw + (it.wb ? ww : 0);
    it.tag = tag; it.ctag = ctag;
    @(negedge clk);
    g_rw = rw; g_ww = ww; g_opnd = opnd;
    it.t0 = cyc;
    q.push_back(it);
    req_valid = 1'b1; req_kind = 2'(k); req_src = 3'(s); req_bit = 3'(b);
    req_pc = pc; req_disp = disp;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd0; req_src = 3'd2; req_bit = 3'd0;
      req_pc = 16'hBEEF; req_disp = 8'h11;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic illegal(input int k, input int s);
    @(negedge clk);
    stray = 0;
    req_valid = 1'b1; req_kind = 2'(k); req_src = 3'(s); req_bit = 3'd0;
    req_pc = 16'h4000; req_disp = 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    checks++;
    if (stray) begin
      errors++;
      $display("FAIL R8 illegal pair %0d/%0d caused activity actual=1 expected=0", k, s);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 0; req_src = 0; req_bit = 0;
    req_pc = 0; req_disp = 0; opnd_rd_ok = 0; opnd_wr_ok = 0; opnd_rd_data = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || opnd_rd !== 1'b0 || opnd_wr !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset outputs actual=%b%b%b expected=000", done, opnd_rd, opnd_wr);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 set/clear tests
    run(0, 2, 3, 16'h1000, 8'h10, 8'h08, 0, 0, 0, "R1", "R6");
    run(0, 2, 3, 16'h1000, 8'h10, 8'hF7, 0, 0, 0, "R1", "R6");
    run(1, 1, 0, 16'h2000, 8'hF0, 8'hFE, 0, 0, 0, "R1", "R5");
    run(1, 3, 7, 16'h2100, 8'h20, 8'h80, 0, 0, 0, "R1", "R5");
    run(0, 3, 7, 16'h2200, 8'h20, 8'h80, 0, 0, 0, "R1", "R5");
    run(0, 0, 1, 16'h2300, 8'h05, 8'h02, 0, 0, 0, "R1", "R5");
    run(1, 0, 1, 16'h2300, 8'h05, 8'h00, 0, 0, 0, "R1", "R5");
    run(1, 2, 4, 16'h2400, 8'h05, 8'h10, 0, 0, 0, "R1", "R5");
    run(1, 4, 4, 16'h2500, 8'h80, 8'h00, 0, 0, 0, "R1", "R5");
    // R2 test-and-clear
    run(2, 1, 5, 16'h3000, 8'h08, 8'hFF, 0, 0, 0, "R2", "R5");
    run(2, 1, 5, 16'h3000, 8'h08, 8'hDF, 0, 0, 0, "R2", "R5");
    run(2, 3, 6, 16'h3100, 8'h08, 8'h41, 0, 3, 0, "R2", "R7");
    run(2, 0, 0, 16'h3200, 8'hFC, 8'h01, 0, 0, 0, "R2", "R5");
    run(2, 4, 2, 16'h3300, 8'h04, 8'h04, 0, 0, 0, "R2", "R5");
    run(2, 2, 7, 16'h3400, 8'h04, 8'h80, 0, 0, 0, "R2", "R5");
    // R6 read waits
    run(0, 4, 2, 16'h3500, 8'h02, 8'h04, 4, 0, 0, "R1", "R6");
    // R3 decrement
    run(3, 5, 0, 16'h4000, 8'h40, 8'h01, 0, 0, 0, "R3", "R5");
    run(3, 6, 0, 16'hFFF0, 8'h7F, 8'h00, 0, 0, 0, "R3", "R5");
    run(3, 5, 0, 16'h0002, 8'h80, 8'h10, 0, 0, 0, "R3", "R5");
    run(3, 0, 0, 16'h5000, 8'hFE, 8'h05, 2, 1, 0, "R3", "R7");
    // R8 busy request ignored
    run(0, 1, 3, 16'h6000, 8'h03, 8'h08, 0, 0, 1, "R8", "R8");
    illegal(3, 2);
    illegal(0, 5);
    illegal(2, 7);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule